// File: doc/BRIEF.md
# Half-Line Vertical Sync Generator

This block produces a programmable vertical sync waveform by counting half-line ticks that an upstream horizontal timing stage supplies. One 32-bit control word sets the length of the vertical cycle in half lines, the number of half lines that the sync pulse stays asserted at the start of each cycle, and the output polarity. The same word also holds a spare mode flag, which is only stored and read back, and a sticky error flag.

The least significant bit of the programmed total selects the scan type. An odd total gives progressive timing. An even total gives interlaced timing, in which a field indicator alternates on every vertical cycle. The total equals twice the line count, minus one. A 262.5-line field is therefore programmed as 524, and a 312.5-line field as 624.

Software writes a new setting at any time. The setting is held in a shadow copy and only moves into the running copy at the next wrap of the counter, so a frame in progress always runs to its end. An invalid sync width raises the error flag, which silences the sync output until software clears it.

Top module: `halfline_vsync_gen`

## Requirements
- R1: Control word layout: total in bits 11:0, sync width in bits 16:12, polarity in bit 17, mode flag in bit 18, error in bit 19. Bits 31:20 ignore writes and always read 0. A read returns the most recently written shadow fields.
- R2: The half-line counter advances by one only in cycles where `half_line_tick` is 1. It runs from 0 up to the running total inclusive and then returns to 0, so each vertical cycle lasts total+1 ticks.
- R3: The sync is active while the counter is below the running sync width. Polarity 0 drives the active level as 0 and the idle level as 1. Polarity 1 drives the active level as 1 and the idle level as 0.
- R4: An even running total (bit 0 = 0) means interlaced, and `field_odd` inverts at every wrap. An odd running total means progressive, and `field_odd` is 0.
- R5: `frame_start` is high for exactly the one cycle in which the counter has just wrapped to 0.
- R6: A written setting becomes the running setting at the first wrap after the write. A write in the same cycle as a wrap waits for the following wrap.
- R7: A write whose sync width is 0, or is greater than its total, sets the error bit. The bit then stays set. While it is set, `vsync_out` sits at the idle level. A write of a valid setting with bit 19 = 1 clears it. A write of an invalid setting keeps it set even with bit 19 = 1.
- R8: During reset, and right after it, every field and the error bit read 0, the counter is 0, `vsync_out` is 1, and `field_odd` and `frame_start` are 0.
- R9: The mode flag (bit 18) has no effect on the outputs and is returned on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_line_tick | input | 1 | One-cycle pulse per half line |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| vsync_out | output | 1 | Vertical sync, polarity applied |
| field_odd | output | 1 | Field indicator, toggles in interlaced mode |
| frame_start | output | 1 | One-cycle pulse when the counter wraps to 0 |

## Verification
A corrupted half-line counter or running setting shows up at `vsync_out` as a pulse edge in the wrong cycle, at the latest by the next wrap. It also shows up at `frame_start` as a frame period other than total+1 ticks. A field bit out of step is visible on the next cycle, because the reference model predicts `field_odd` every clock. A wrong error state shows up in the read word one cycle after the write that should have changed it, and it also silences or releases the sync in that same cycle.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  localparam int TOTAL_W  = 12;
  localparam int WIDTH_W  = 5;
  localparam int REG_W    = 32;
  localparam int WIDTH_LSB = TOTAL_W;
  localparam int POL_BIT  = WIDTH_LSB + WIDTH_W;
  localparam int MODE_BIT = POL_BIT + 1;
  localparam int ERR_BIT  = MODE_BIT + 1;
  localparam int USED_W   = ERR_BIT + 1;

  typedef struct packed {
    logic               mode;
    logic               pol;
    logic [WIDTH_W-1:0] width;
    logic [TOTAL_W-1:0] total;
  } vsg_cfg_t;
endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
  import vsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output vsg_cfg_t         shadow_q,
  output logic             err_d,
  output logic             err_q,
  output logic [REG_W-1:0] rdata
);
  vsg_cfg_t         wr_cfg;
  logic [TOTAL_W:0] width_ext;
  logic [TOTAL_W:0] total_ext;
  logic             bad_width;

  always_comb begin
    wr_cfg.total = wdata[TOTAL_W-1:0];
    wr_cfg.width = wdata[WIDTH_LSB +: WIDTH_W];
    wr_cfg.pol   = wdata[POL_BIT];
    wr_cfg.mode  = wdata[MODE_BIT];
    width_ext    = (TOTAL_W+1)'(wr_cfg.width);
    total_ext    = (TOTAL_W+1)'(wr_cfg.total);
    bad_width    = (wr_cfg.width == '0) || (width_ext > total_ext);
  end

  always_comb begin
    err_d = err_q;
    if (wr_en) begin
      if (bad_width)           err_d = 1'b1;
      else if (wdata[ERR_BIT]) err_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr_en) shadow_q <= wr_cfg;
      err_q <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[USED_W-1:0] = {err_q, shadow_q};
  end
endmodule

// File: rtl/vsg_counter.sv
module vsg_counter
  import vsg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  vsg_cfg_t           shadow,
  output logic [TOTAL_W-1:0] cnt_q,
  output logic [TOTAL_W-1:0] cnt_d,
  output vsg_cfg_t           run_q,
  output vsg_cfg_t           run_d,
  output logic               field_q,
  output logic               start_q
);
  logic wrap;
  logic field_d;

  always_comb begin
    wrap    = tick && (cnt_q == run_q.total);
    run_d   = wrap ? shadow : run_q;
    cnt_d   = cnt_q;
    field_d = field_q;
    if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    if (wrap) field_d = shadow.total[0] ? 1'b0 : ~field_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      run_q   <= '0;
      field_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      field_q <= field_d;
      start_q <= wrap;
    end
  end
endmodule

// File: rtl/vsg_sync_out.sv
module vsg_sync_out
  import vsg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [TOTAL_W-1:0] cnt_d,
  input  vsg_cfg_t           run_d,
  input  logic               err_d,
  output logic               vsync_q
);
  logic in_pulse;

  always_comb
    in_pulse = !err_d && (cnt_d < (TOTAL_W)'(run_d.width));

  always_ff @(posedge clk) begin
    if (rst) vsync_q <= 1'b1;
    else     vsync_q <= in_pulse ? run_d.pol : ~run_d.pol;
  end
endmodule

// File: rtl/halfline_vsync_gen.sv
module halfline_vsync_gen
  import vsg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        half_line_tick,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        vsync_out,
  output logic        field_odd,
  output logic        frame_start
);
  vsg_cfg_t           shadow_cfg;
  vsg_cfg_t           run_cfg;
  vsg_cfg_t           run_next;
  logic [TOTAL_W-1:0] hl_cnt;
  logic [TOTAL_W-1:0] hl_cnt_next;
  logic               err_next;
  logic               err_flag;

  vsg_regs regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .shadow_q(shadow_cfg), .err_d(err_next), .err_q(err_flag), .rdata(reg_rdata)
  );

  vsg_counter cnt_i (
    .clk(clk), .rst(rst), .tick(half_line_tick), .shadow(shadow_cfg),
    .cnt_q(hl_cnt), .cnt_d(hl_cnt_next), .run_q(run_cfg), .run_d(run_next),
    .field_q(field_odd), .start_q(frame_start)
  );

  vsg_sync_out out_i (
    .clk(clk), .rst(rst), .cnt_d(hl_cnt_next), .run_d(run_next),
    .err_d(err_next), .vsync_q(vsync_out)
  );
endmodule

// File: rtl/halfline_vsync_gen_chk.sv
module halfline_vsync_gen_chk
  import vsg_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               half_line_tick,
  input logic [31:0]        reg_rdata,
  input logic               vsync_out,
  input logic               field_odd,
  input logic               frame_start,
  input logic [TOTAL_W-1:0] hl_cnt,
  input vsg_cfg_t           run_cfg
);
  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    hl_cnt <= run_cfg.total);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !half_line_tick |=> $stable(hl_cnt));
  // R5
  start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> hl_cnt == '0);
  // R5
  start_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> $past(half_line_tick));
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[ERR_BIT] |-> vsync_out != run_cfg.pol);
  // R4
  prog_field_chk: assert property (@(posedge clk) disable iff (rst)
    run_cfg.total[0] |-> !field_odd);
  // R4
  field_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !run_cfg.total[0]) |-> field_odd != $past(field_odd));
endmodule

bind halfline_vsync_gen halfline_vsync_gen_chk chk_i (
  .clk(clk), .rst(rst), .half_line_tick(half_line_tick), .reg_rdata(reg_rdata),
  .vsync_out(vsync_out), .field_odd(field_odd), .frame_start(frame_start),
  .hl_cnt(hl_cnt), .run_cfg(run_cfg)
);

// File: tb/halfline_vsync_gen_tb_top.sv
module halfline_vsync_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        vsync, field, fstart;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int gap = 2;
  bit tick_en = 0;

  // reference model state
  int m_cnt = 0, m_field = 0, m_fs = 0, m_vs = 1, m_err = 0;
  int s_tot = 0, s_wid = 0, s_pol = 0, s_mode = 0;
  int a_tot = 0, a_wid = 0, a_pol = 0;
  int tk = 0, exp_per = 0;
  bit seen_fs = 0;

  always #10 clk = ~clk;

  halfline_vsync_gen dut_i (
    .clk(clk), .rst(rst), .half_line_tick(tick), .reg_wr_en(wr_en),
    .reg_wdata(wdata), .reg_rdata(rdata), .vsync_out(vsync),
    .field_odd(field), .frame_start(fstart)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick <= tick_en && (cyc % gap == 0);
  end

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_field = 0; m_fs = 0; m_vs = 1; m_err = 0;
      s_tot = 0; s_wid = 0; s_pol = 0; s_mode = 0;
      a_tot = 0; a_wid = 0; a_pol = 0; tk = 0; seen_fs = 0;
    end else begin
      bit wrap;
      wrap = tick && (m_cnt == a_tot);
      if (tick) tk++;
      if (wrap) begin
        exp_per = a_tot + 1;
        a_tot = s_tot; a_wid = s_wid; a_pol = s_pol;
        m_field = (s_tot % 2 == 0) ? !m_field : 0;
      end
      if (tick) m_cnt = wrap ? 0 : m_cnt + 1;
      m_fs = wrap;
      if (wr_en) begin
        int nt, nw;
        nt = int'(wdata[11:0]);
        nw = int'(wdata[16:12]);
        if (nw == 0 || nw > nt) m_err = 1;
        else if (wdata[19]) m_err = 0;
        s_tot = nt; s_wid = nw; s_pol = wdata[17]; s_mode = wdata[18];
      end
      m_vs = (!m_err && m_cnt < a_wid) ? a_pol : !a_pol;
    end
  end

  always @(posedge clk) begin
    #5;
    if (!rst) begin
      int exp_rd;
      exp_rd = (m_err << 19) | (s_mode << 18) | (s_pol << 17) | (s_wid << 12) | s_tot;
      check("R1 read word", int'(rdata), exp_rd);
      check("R3/R6/R7 vsync level", vsync, m_vs);
      check("R4 field", field, m_field);
      check("R5 frame_start", fstart, m_fs);
      if (fstart) begin
        if (seen_fs) check("R2 ticks per vertical cycle", tk, exp_per);
        seen_fs = 1;
        tk = 0;
      end
    end
  end

  task automatic wr(input int tot, input int wid, input int pol, input int mode,
                    input int clr, input int resv);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = (resv << 20) | (clr << 19) | (mode << 18) | (pol << 17) | (wid << 12) | tot;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(4);
    // R8 reset state
    check("R8 read word in reset", int'(rdata), 0);
    check("R8 vsync in reset", vsync, 1);
    check("R8 field in reset", field, 0);
    check("R8 frame_start in reset", fstart, 0);
    @(negedge clk) rst = 1'b0;
    idle(2);
    check("R8 vsync after reset", vsync, 1);
    check("R8 read word after reset", int'(rdata), 0);
    tick_en = 1;

    // 262.5-line interlaced field, active low
    gap = 2;
    wr(524, 6, 0, 0, 0, 0);
    idle(3300);
    // 312.5-line interlaced field, active high, written mid-frame (R6)
    gap = 3;
    wr(624, 10, 1, 0, 0, 'hABC);
    check("R1 reserved bits read zero", int'(rdata[31:20]), 0);
    idle(5900);
    // progressive, odd total, mode flag set
    gap = 1;
    wr(525, 3, 0, 1, 0, 0);
    check("R9 mode flag readback", rdata[18], 1);
    idle(1700);

    // error handling
    wr(525, 0, 0, 0, 0, 0);
    check("R7 zero width sets error", rdata[19], 1);
    check("R7 vsync idle under error", vsync, 1);
    idle(600);
    wr(20, 21, 0, 0, 1, 0);
    check("R7 invalid write keeps error", rdata[19], 1);
    idle(50);
    wr(20, 4, 1, 0, 1, 0);
    check("R7 valid clear", rdata[19], 0);
    idle(200);
    wr(4, 5, 0, 0, 0, 0);
    check("R7 width above total", rdata[19], 1);
    idle(40);
    wr(5, 5, 0, 0, 1, 0);
    check("R7 width equal total+0 accepted", rdata[19], 0);
    idle(200);
    wr(7, 1, 1, 1, 0, 0);
    idle(200);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule